// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block chooses the source for a retained-memory supply rail: the main supply or a backup battery. It sees three digital flags from external comparators: the main supply is above the reset threshold, the main supply is above the battery voltage, and the battery is above its minimum usable level. It drives one enable for each of the two power switches and a status bit that reports battery mode.

The battery is chosen only when three things are true together: the main supply is under the reset threshold, it is under the battery voltage, and the battery is above its minimum level. The main supply therefore keeps the rail during normal operation even when the battery voltage is higher. When any of the three conditions goes away, the rail goes back to the main supply.

Every change of source passes through a break interval of `DEAD_CYCLES` clocks with both switches open, so the two switches are never closed together. The flags come from the analog domain and pass through a synchronizer of `SYNC_STAGES` flops before the state machine uses them. The state machine has four states:
- MAIN: the main switch is closed.
- GAP_TO_BAT: break on the way to the battery.
- BAT: the battery switch is closed.
- GAP_TO_MAIN: break on the way to the main supply.

The transitions are:
- engage (MAIN to GAP_TO_BAT): the battery demand appears.
- settle-bat (GAP_TO_BAT to BAT): the break ends and the demand is still present.
- release (BAT to GAP_TO_MAIN): the battery demand goes away.
- settle-main (GAP_TO_MAIN to MAIN): the break ends and the demand is still absent.
- reverse: during a break the demand flips. The machine moves to the opposite break state and a full break starts again.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: During reset and right after it, `main_en_o`=1, `bat_en_o`=0 and `bat_mode_o`=0.
- R2: While the synchronized `main_ok_i` is 1, the battery switch is never selected, whatever the other two flags are.
- R3: The battery switch is selected only while `main_ok_i`=0, `main_gt_bat_i`=0 and `bat_ok_i`=1 all hold.
- R4: In battery mode, setting `main_ok_i`=1 or `main_gt_bat_i`=1 returns the rail to the main supply.
- R5: While `bat_ok_i`=0, the rail uses the main supply whatever the other flags are.
- R6: `main_en_o` and `bat_en_o` are never 1 in the same cycle.
- R7: Every change of source holds both enables at 0 for exactly `DEAD_CYCLES` cycles before the new enable rises.
- R8: A flag change applied before clock edge k first shows at the outputs after edge k+`SYNC_STAGES`. A flag pattern that does not change the selected source leaves all outputs unchanged.
- R9: `bat_mode_o` is 1 exactly in the cycles where `bat_en_o` is 1.
- R10: If the demand flips during a break, the abandoned switch is never closed. A new break of `DEAD_CYCLES` cycles starts toward the other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| main_ok_i | input | 1 | Main supply above the reset threshold (asynchronous) |
| main_gt_bat_i | input | 1 | Main supply above the battery voltage (asynchronous) |
| bat_ok_i | input | 1 | Battery above its minimum level (asynchronous) |
| main_en_o | output | 1 | Main-path switch enable |
| bat_en_o | output | 1 | Battery-path switch enable |
| bat_mode_o | output | 1 | Battery mode status |

## Verification
A wrong state or a wrong transition shows at the enables within `SYNC_STAGES`+1 cycles of the flag change that exposes it. Examples are a missed abort, a premature settle, or the battery being taken while the main supply is good. A break counter that is off by one shows as a gap one cycle too short or too long. The bench therefore checks every cycle of every change, not only the settled values. It does this from both settled sources for all eight flag patterns, and it also covers a demand that flips during a break.

// File: rtl/bkup_pkg.sv
package bkup_pkg;

    // Bit positions of the synchronized flag vector
    localparam int unsigned FLG_MAIN_OK  = 0;
    localparam int unsigned FLG_MAIN_GT  = 1;
    localparam int unsigned FLG_BAT_OK   = 2;
    localparam int unsigned FLG_COUNT    = 3;

    typedef enum logic [1:0] {
        SRC_MAIN        = 2'd0,
        SRC_GAP_TO_BAT  = 2'd1,
        SRC_BAT         = 2'd2,
        SRC_GAP_TO_MAIN = 2'd3
    } src_state_t;

    // Battery is demanded only when the main rail is both below the reset
    // threshold and below the battery, and the battery itself is usable.
    function automatic logic bat_demand(input logic [FLG_COUNT-1:0] flg);
        return (!flg[FLG_MAIN_OK]) && (!flg[FLG_MAIN_GT]) && flg[FLG_BAT_OK];
    endfunction

endpackage

// File: rtl/bkup_flag_sync.sv
module bkup_flag_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain[s] <= '0;
                else         chain[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain[s] <= '0;
                else         chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/bkup_gap_timer.sv
module bkup_gap_timer #(
    parameter int unsigned DEAD_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic done_o
);

    localparam int unsigned CNT_W = $clog2(DEAD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DEAD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (load_i)       cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/bkup_switch_ctrl.sv
module bkup_switch_ctrl
    import bkup_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEAD_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic main_ok_i,
    input  logic main_gt_bat_i,
    input  logic bat_ok_i,
    output logic main_en_o,
    output logic bat_en_o,
    output logic bat_mode_o
);

    logic [FLG_COUNT-1:0] flg_raw;
    logic [FLG_COUNT-1:0] flg_s;
    logic                 want_bat;
    logic                 gap_load;
    logic                 gap_done;
    src_state_t           st_q;
    src_state_t           st_d;

    always_comb begin
        flg_raw              = '0;
        flg_raw[FLG_MAIN_OK] = main_ok_i;
        flg_raw[FLG_MAIN_GT] = main_gt_bat_i;
        flg_raw[FLG_BAT_OK]  = bat_ok_i;
    end

    bkup_flag_sync #(
        .WIDTH  (FLG_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (flg_raw),
        .sync_o  (flg_s)
    );

    assign want_bat = bat_demand(flg_s);

    bkup_gap_timer #(
        .DEAD_CYCLES (DEAD_CYCLES)
    ) u_gap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (gap_load),
        .done_o (gap_done)
    );

    // Next-state logic
    always_comb begin
        st_d     = st_q;
        gap_load = 1'b0;
        unique case (st_q)
            SRC_MAIN: begin
                if (want_bat) begin          // engage
                    st_d     = SRC_GAP_TO_BAT;
                    gap_load = 1'b1;
                end
            end
            SRC_GAP_TO_BAT: begin
                if (!want_bat) begin         // reverse
                    st_d     = SRC_GAP_TO_MAIN;
                    gap_load = 1'b1;
                end else if (gap_done) begin // settle-bat
                    st_d     = SRC_BAT;
                end
            end
            SRC_BAT: begin
                if (!want_bat) begin         // release
                    st_d     = SRC_GAP_TO_MAIN;
                    gap_load = 1'b1;
                end
            end
            SRC_GAP_TO_MAIN: begin
                if (want_bat) begin          // reverse
                    st_d     = SRC_GAP_TO_BAT;
                    gap_load = 1'b1;
                end else if (gap_done) begin // settle-main
                    st_d     = SRC_MAIN;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= SRC_MAIN;
        else         st_q <= st_d;
    end

    // Registered, glitch-free outputs aligned with the state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            main_en_o  <= 1'b1;
            bat_en_o   <= 1'b0;
            bat_mode_o <= 1'b0;
        end else begin
            main_en_o  <= (st_d == SRC_MAIN);
            bat_en_o   <= (st_d == SRC_BAT);
            bat_mode_o <= (st_d == SRC_BAT);
        end
    end

endmodule

// File: rtl/bkup_switch_chk.sv
module bkup_switch_chk (
    input logic clk,
    input logic rst_n,
    input logic main_en,
    input logic bat_en,
    input logic bat_mode,
    input logic main_ok_s,
    input logic bat_ok_s
);

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_en && bat_en)); // R6

    AST_BAT_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bat_en) |-> $past(!main_en && !bat_en)); // R7

    AST_MAIN_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_en) |-> $past(!main_en && !bat_en)); // R7

    AST_MAIN_GOOD_NO_BAT: assert property (@(posedge clk) disable iff (!rst_n)
        main_ok_s |=> !bat_en); // R2

    AST_LOW_BAT_NO_BAT: assert property (@(posedge clk) disable iff (!rst_n)
        !bat_ok_s |=> !bat_en); // R5

    AST_MODE_IMPLIES_BAT: assert property (@(posedge clk) disable iff (!rst_n)
        bat_mode |-> bat_en); // R9

    AST_BAT_IMPLIES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        bat_en |-> bat_mode); // R9

endmodule

bind bkup_switch_ctrl bkup_switch_chk u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .main_en   (main_en_o),
    .bat_en    (bat_en_o),
    .bat_mode  (bat_mode_o),
    .main_ok_s (flg_s[0]),
    .bat_ok_s  (flg_s[2])
);

// File: tb/sim_bkup_switch_ctrl.sv
module sim_bkup_switch_ctrl;

    localparam int unsigned SYNC = 2;
    localparam int unsigned DEAD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_ok = 1'b1, main_gt = 1'b1, bat_ok = 1'b1;
    logic main_en, bat_en, bat_mode;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bkup_switch_ctrl #(.SYNC_STAGES(SYNC), .DEAD_CYCLES(DEAD)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .main_ok_i(main_ok), .main_gt_bat_i(main_gt), .bat_ok_i(bat_ok),
        .main_en_o(main_en), .bat_en_o(bat_en), .bat_mode_o(bat_mode)
    );

    // exp: 0 = main, 1 = gap (both off), 2 = battery
    task automatic check(input int exp, input string tag);
        logic em, eb;
        em = (exp == 0);
        eb = (exp == 2);
        n_vec++;
        if (main_en !== em || bat_en !== eb || bat_mode !== eb) begin
            n_bad++;
            $display("FAIL %s: main_en/bat_en/bat_mode = %b%b%b, expected %b%b%b",
                     tag, main_en, bat_en, bat_mode, em, eb, eb);
        end
    endtask

    task automatic apply(input logic mo, input logic mg, input logic bo);
        main_ok = mo; main_gt = mg; bat_ok = bo;
    endtask

    task automatic settle(input bit to_bat);
        if (to_bat) apply(1'b0, 1'b0, 1'b1);
        else        apply(1'b1, 1'b1, 1'b1);
        repeat (SYNC + DEAD + 3) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(0, "R1 after reset");

        // Sweep: both settled sources x all eight flag patterns
        for (int start = 0; start < 2; start++) begin
            for (int pat = 0; pat < 8; pat++) begin
                logic mo, mg, bo;
                bit want, change;
                int old_s, new_s;
                string tag;
                settle(start[0]);
                mo = pat[0]; mg = pat[1]; bo = pat[2];
                want   = !mo && !mg && bo;
                old_s  = start * 2;
                new_s  = want ? 2 : 0;
                change = (old_s != new_s);
                if (!bo)            tag = "R5 R7 R8";
                else if (mo)        tag = "R2 R4 R7 R8";
                else if (mg)        tag = "R4 R7 R8";
                else                tag = "R3 R7 R8 R9";
                apply(mo, mg, bo);
                for (int i = 1; i <= int'(SYNC + DEAD + 2); i++) begin
                    @(negedge clk);
                    if (!change || i <= int'(SYNC)) check(old_s, tag);
                    else if (i <= int'(SYNC + DEAD)) check(1, tag);
                    else check(new_s, tag);
                end
            end
        end

        // Demand flips during the break toward the battery
        settle(1'b0);
        apply(1'b0, 1'b0, 1'b1);
        for (int i = 1; i <= int'(2 * SYNC + DEAD + 3); i++) begin
            @(negedge clk);
            if (i == int'(SYNC + 1)) apply(1'b1, 1'b0, 1'b1);
            // reaction at edge 2*SYNC+2, new break of DEAD cycles follows
            if (i <= int'(SYNC)) check(0, "R10 before gap");
            else if (i < int'(2 * SYNC + 2 + DEAD)) check(1, "R10 abandoned battery");
            else check(0, "R10 back to main");
        end

        // Demand flips during the break toward main
        settle(1'b1);
        apply(1'b0, 1'b1, 1'b1);
        for (int i = 1; i <= int'(2 * SYNC + DEAD + 3); i++) begin
            @(negedge clk);
            if (i == int'(SYNC + 1)) apply(1'b0, 1'b0, 1'b1);
            if (i <= int'(SYNC)) check(2, "R10 before gap");
            else if (i < int'(2 * SYNC + 2 + DEAD)) check(1, "R10 abandoned main");
            else check(2, "R10 back to battery");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule